// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank: Direction and Data

This block is a bank of general-purpose pins controlled through a simple register port. Each pin has a direction bit and an output data bit that software writes, and each pin's pad level is brought in through a two-stage synchroniser and presented as a read-only input word. The pad output enable follows the direction bit and the pad output value follows the output data bit.

Pins are packed 32 to a word. Every word has four register slots: direction, output data, synchronised input, and a merged level view. The merged view returns, bit by bit, the output data bit for pins configured as outputs and the synchronised input bit for pins configured as inputs. The output data register is held independently of direction, so software can preload a level before turning a pin around and the pad never glitches to a stale value.

The register port takes one request per cycle. Writes take effect at the clock edge that accepts them. Reads answer one cycle later with a response-valid strobe.

Top module: `pinbank`

## Requirements
- R1: After reset every direction and output data bit is 0, so pad_oe and pad_out are all 0, and every register reads 0 while the pads are low.
- R2: Word w occupies byte addresses w*16 to w*16+15. The slot at offset 0 is direction, 4 is output data, 8 is synchronised input and 12 is the merged view. Pin n is bit n%32 of word n/32 in every slot.
- R3: pad_oe equals the stored direction bits and pad_out equals the stored output data bits. A write is visible on the pads at the first falling edge after the rising edge that accepts it.
- R4: The output data register keeps its value whatever the direction bits are. Writing it while a pin is an input leaves pad_oe unchanged, and the stored value appears on the pad once the direction bit is set.
- R5: A pad level present before rising edge k can be read from the input slot by a read accepted at edge k+2. A read accepted at edge k+1 still returns the previous level.
- R6: The input slot and the merged view slot are read-only. Writes to them change no register and no pad.
- R7: In the merged view, bit i equals the output data bit when direction bit i is 1 and the synchronised input bit when it is 0.
- R8: A read accepted at rising edge k sets rsp_valid with rsp_rdata in the following cycle. rsp_valid is 0 in cycles that follow no read. A read in the cycle right after a write returns the written value.
- R9: Bit positions at or above NUM_PINS in the last word read as 0 in every slot, and writes to them are dropped.
- R10: An address whose bits [1:0] are not 00, or whose word index is NUM_WORDS or more, reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables, 1 drives the pad |
| pad_out | output | NUM_PINS | Pad output values |

## Verification
A direction change and a merged-view read can fall on adjacent edges. The view must then pick its source from the direction just written. The bench provokes this with a direction write followed at once by a view read, and with a pad toggle landing while a pin turns into an output. The response is judged against a model that selects output data or pad level per bit, using the direction after the write and the pad level that has cleared both synchroniser stages. The bench also reads the input slot exactly one edge too early, then exactly in time, to pin down the synchroniser latency.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned WORD_SPAN_LG = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        KIND_DIR  = 2'd0,
        KIND_DOUT = 2'd1,
        KIND_DIN  = 2'd2,
        KIND_VIEW = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.s1 = async_in;
        state_d.s2 = state_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_out = state_q.s2;

endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned IDX_W     = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output reg_kind_e         kind
);

    localparam int unsigned WF_W = ADDR_W - WORD_SPAN_LG;

    logic [WF_W-1:0] word_field;

    always_comb begin
        word_field = addr[ADDR_W-1:WORD_SPAN_LG];
        kind       = reg_kind_e'(addr[3:2]);
        idx        = word_field[IDX_W-1:0];
        hit        = (addr[1:0] == 2'b00) && (int'(word_field) < int'(NUM_WORDS));
    end

endmodule

// File: rtl/pinbank_word.sv
module pinbank_word
    import pinbank_pkg::*;
#(
    parameter int unsigned LIVE_BITS = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_dir,
    input  logic  wr_dout,
    input  word_t wdata,
    output word_t dir_q,
    output word_t dout_q
);

    localparam logic [WORD_W:0] TOP_BIT   = (WORD_W + 1)'(1) << LIVE_BITS;
    localparam word_t           LIVE_MASK = WORD_W'(TOP_BIT - 1'b1);

    typedef struct packed {
        word_t dir;
        word_t dout;
    } word_state_t;

    word_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_dir) begin
            state_d.dir = wdata & LIVE_MASK;
        end
        if (wr_dout) begin
            state_d.dout = wdata & LIVE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dir_q  = state_q.dir;
    assign dout_q = state_q.dout;

endmodule

// File: rtl/pinbank.sv
module pinbank
    import pinbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 40,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    localparam int unsigned NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned PAD_W     = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic  rsp_valid;
        word_t rsp_rdata;
    } port_state_t;

    port_state_t state_d, state_q;

    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    reg_kind_e         dec_kind;
    logic [NUM_PINS-1:0] din_sync;
    logic [PAD_W-1:0]  din_all;
    word_t             dir_words  [NUM_WORDS];
    word_t             dout_words [NUM_WORDS];
    word_t             din_words  [NUM_WORDS];
    logic              wr_dir     [NUM_WORDS];
    logic              wr_dout    [NUM_WORDS];

    pinbank_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr (req_addr),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .kind (dec_kind)
    );

    pinbank_sync #(
        .W (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    assign din_all = PAD_W'(din_sync);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int unsigned REMAIN = NUM_PINS - w * WORD_W;
        localparam int unsigned LIVE   = (REMAIN >= WORD_W) ? WORD_W : REMAIN;

        always_comb begin
            wr_dir[w]  = req_valid && req_write && dec_hit &&
                         (int'(dec_idx) == w) && (dec_kind == KIND_DIR);
            wr_dout[w] = req_valid && req_write && dec_hit &&
                         (int'(dec_idx) == w) && (dec_kind == KIND_DOUT);
        end

        assign din_words[w] = din_all[w*WORD_W +: WORD_W];

        pinbank_word #(
            .LIVE_BITS (LIVE)
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dir  (wr_dir[w]),
            .wr_dout (wr_dout[w]),
            .wdata   (req_wdata),
            .dir_q   (dir_words[w]),
            .dout_q  (dout_words[w])
        );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pad_oe[p]  = dir_words[p / WORD_W][p % WORD_W];
        assign pad_out[p] = dout_words[p / WORD_W][p % WORD_W];
    end

    always_comb begin
        word_t sel_dir;
        word_t sel_dout;
        word_t sel_din;
        word_t rd_word;

        sel_dir  = '0;
        sel_dout = '0;
        sel_din  = '0;
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (int'(dec_idx) == w) begin
                sel_dir  = dir_words[w];
                sel_dout = dout_words[w];
                sel_din  = din_words[w];
            end
        end

        rd_word = '0;
        if (dec_hit) begin
            unique case (dec_kind)
                KIND_DIR:  rd_word = sel_dir;
                KIND_DOUT: rd_word = sel_dout;
                KIND_DIN:  rd_word = sel_din;
                KIND_VIEW: rd_word = (sel_dir & sel_dout) | (~sel_dir & sel_din);
                default:   rd_word = '0;
            endcase
        end

        state_d           = state_q;
        state_d.rsp_valid = req_valid && !req_write;
        if (req_valid && !req_write) begin
            state_d.rsp_rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_rdata = state_q.rsp_rdata;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int unsigned NUM_PINS = 40,
    parameter int unsigned ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [31:0]         req_wdata,
    input logic                rsp_valid,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);

    localparam int unsigned W0 = (NUM_PINS < 32) ? NUM_PINS : 32;

    logic wr_any;
    logic wr_dir0;
    logic wr_dout0;
    logic wr_ro_slot;

    assign wr_any     = req_valid && req_write;
    assign wr_dir0    = wr_any && (req_addr == ADDR_W'(0));
    assign wr_dout0   = wr_any && (req_addr == ADDR_W'(4));
    assign wr_ro_slot = wr_any && req_addr[3];

    // R8: a read is answered in the next cycle
    p_rsp_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R8: no response without a read
    p_no_stray_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R3: pads move only on writes
    p_pads_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(pad_oe) && $stable(pad_out)));

    // R3: direction write of word 0 lands on the enables
    p_dir_to_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir0 |=> (pad_oe[W0-1:0] == $past(req_wdata[W0-1:0])));

    // R4: output data writes leave the enables alone
    p_dout_keeps_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dout0 |=> $stable(pad_oe));

    // R6: writes to input or view slots touch no pad
    p_ro_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro_slot |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind pinbank pinbank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_pinbank.sv
`timescale 1ns/1ps
module sim_pinbank;

    localparam int NP = 40;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    logic [NP-1:0] m_dir  = '0;
    logic [NP-1:0] m_dout = '0;
    logic [NP-1:0] m_din  = '0;

    always #10 clk = ~clk;

    pinbank #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [31:0] slice(logic [NP-1:0] v, int w);
        logic [63:0] t;
        t = 64'(v);
        return t[w*32 +: 32];
    endfunction

    function automatic logic [31:0] view_word(int w);
        return (slice(m_dir, w) & slice(m_dout, w)) | (~slice(m_dir, w) & slice(m_din, w));
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_pad(logic [NP-1:0] v);
        pad_in = v;
        @(negedge clk);
        @(negedge clk);
        m_din = v;
    endtask

    // monitor: pops the scoreboard as responses arrive
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected response actual=%0h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), {32'h0, rsp_rdata}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 64'(pad_oe), 64'h0);
        check("R1 pad_out", 64'(pad_out), 64'h0);
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 4; k++) rd(AW'(w*16 + k*4), 32'h0, "R1 reset read");
        end

        // R2/R4 output data written while input: no enable
        wr(8'h04, 32'hA5A5_0F0F); m_dout[31:0] = 32'hA5A5_0F0F;
        check("R4 oe unchanged", 64'(pad_oe), 64'h0);
        check("R3 pad_out follows dout", 64'(pad_out), 64'(m_dout));
        rd(8'h04, 32'hA5A5_0F0F, "R2 dout slot");

        // R5 synchroniser latency: one edge early, then on time
        pad_in = 40'hC3_1234_5678;
        @(negedge clk);
        rd(8'h08, 32'h0, "R5 early read old level");
        m_din = 40'hC3_1234_5678;
        rd(8'h08, 32'h1234_5678, "R5 read after two stages");
        rd(8'h18, 32'h0000_00C3, "R5 R9 word1 input");

        // R7/R8 direction write then immediate view read
        wr(8'h00, 32'h0000_FFFF); m_dir[31:0] = 32'h0000_FFFF;
        rd(8'h0C, view_word(0), "R7 R8 view after dir write");
        check("R3 oe follows dir", 64'(pad_oe), 64'(m_dir));
        check("R4 held dout drives", 64'(pad_out & pad_oe), 64'(m_dout & m_dir));

        // R9 partial last word
        wr(8'h10, 32'hFFFF_FFFF); m_dir[39:32] = 8'hFF;
        rd(8'h10, 32'h0000_00FF, "R9 dir word1 masked");
        wr(8'h14, 32'hFFFF_FF5A); m_dout[39:32] = 8'h5A;
        rd(8'h14, 32'h0000_005A, "R9 dout word1 masked");
        check("R3 word1 pads", 64'(pad_out[39:32]), 64'h5A);
        rd(8'h1C, view_word(1), "R7 view word1 all outputs");

        // R6 read-only slots
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0000_0000);
        rd(8'h08, slice(m_din, 0), "R6 din unchanged");
        rd(8'h0C, view_word(0), "R6 view unchanged");
        rd(8'h00, slice(m_dir, 0), "R6 dir unchanged");
        check("R6 pads oe", 64'(pad_oe), 64'(m_dir));
        check("R6 pads out", 64'(pad_out), 64'(m_dout));

        // R10 unmapped and misaligned
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R10 beyond last word");
        rd(8'h01, 32'h0, "R10 misaligned");
        rd(8'hF0, 32'h0, "R10 high address");
        check("R10 pads oe", 64'(pad_oe), 64'(m_dir));
        check("R10 pads out", 64'(pad_out), 64'(m_dout));

        // R7 pad toggle while some pins become outputs
        pad_in = 40'h3C_EDCB_A987;
        wr(8'h00, 32'h00FF_FFFF); m_dir[31:0] = 32'h00FF_FFFF;
        @(negedge clk);
        m_din = 40'h3C_EDCB_A987;
        rd(8'h0C, view_word(0), "R7 view mixed after toggle");
        rd(8'h1C, view_word(1), "R7 view word1 outputs ignore pad");

        // R3 dout write on output pins reaches pads
        wr(8'h04, 32'h1357_9BDF); m_dout[31:0] = 32'h1357_9BDF;
        check("R3 pad_out updated", 64'(pad_out), 64'(m_dout));

        // R4 back to input: dout retained
        wr(8'h00, 32'h0); m_dir[31:0] = 32'h0;
        check("R4 oe cleared", 64'(pad_oe[31:0]), 64'h0);
        rd(8'h04, 32'h1357_9BDF, "R4 dout retained");
        rd(8'h0C, slice(m_din, 0), "R7 view all inputs");
        set_pad(40'h00_0000_FFFF);
        rd(8'h0C, 32'h0000_FFFF, "R5 R7 view follows new pad");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule